// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block sits between an 8-bit processor core and its external bus. The core asks for one bus cycle at a time by giving a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then steps through the T-states of that cycle and drives the bus pins. The high address byte has its own output. The low address byte and the data share one 8-bit path. In the first T-state the low address goes out on that path, and an address-latch strobe lets external logic hold it. After that the path carries the data, driven by the block for writes and left undriven for reads.

Status lines and an I/O-versus-memory line tell the outside world what kind of cycle is running. A slow device can hold the ready input low to stretch a strobed cycle with wait states. When the cycle ends, the core gets a one-cycle done pulse and, for reads, the byte that was captured from the bus. The shared path is shown as a separate output value, an output enable and an input value, so the pad ring can build the tristate buffer.

Top module: `muxbus_cycle_seq`

## Requirements
- R1: Kind codes on req_kind are 0 bus idle, 1 opcode fetch, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write, 6 interrupt acknowledge, and 7 behaves as bus idle. While busy, {s1,s0}/io_m are 11/0 for fetch, 10/0 for memory read, 01/0 for memory write, 10/1 for I/O read, 01/1 for I/O write, 11/1 for interrupt acknowledge and 00/0 for bus idle. They stay constant for the whole cycle and are all 0 when not busy.
- R2: ale is high only in T1 of a non-idle cycle. In that T1, ad_oe is 1 and ad_out equals address bits 7..0. addr_hi equals address bits 15..8 in every T-state of the cycle.
- R3: For the read kinds (fetch, memory read, I/O read, interrupt acknowledge), rd_n is low in T2, in every wait state and in T3, and high otherwise. ad_oe is 0 in every T-state after T1.
- R4: For the write kinds, wr_n is low in T2, in every wait state and in T3, and high otherwise. While wr_n is low, ad_oe is 1 and ad_out equals the write byte.
- R5: A cycle lasts, without waits and counted from the clock edge that accepts it, 4 T-states for a fetch (6 with req_long), 3 for each memory or I/O transfer, 6 for interrupt acknowledge (12 with req_long) and 2 for bus idle (3 with req_long). The T-states after T3 drive no strobe and do not drive the shared path.
- R6: ready is sampled at the end of T2 and at the end of each wait state of a strobed cycle. Each low sample adds one wait state, during which the strobe and the path direction do not change.
- R7: A bus idle cycle raises no ale, rd_n or wr_n and does not drive the shared path. Its length does not depend on ready.
- R8: done is a one-cycle pulse in the clock cycle after the last T-state. For read kinds, rdata then holds ad_in as sampled at the end of T3. Write and idle cycles leave rdata unchanged.
- R9: After reset, busy and done are 0, ale and ad_oe are 0, rd_n and wr_n are 1, and rdata is 0.
- R10: A request is taken only when req_valid is high while busy is low. A request presented while busy has no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core asks for a bus cycle |
| req_kind | input | 3 | Cycle kind code |
| req_long | input | 1 | Selects the longer variant of fetch, acknowledge or idle |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| ready | input | 1 | Device ready; low stretches the cycle |
| ad_in | input | 8 | Value seen on the shared address/data path |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Cycle-complete pulse |
| rdata | output | 8 | Byte captured by the last read cycle |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven on the shared path |
| ad_oe | output | 1 | Drive enable for the shared path |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | High for I/O cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
On every cycle, the assertions check that the two strobes never overlap, that ale never coincides with a strobe and lasts only one cycle, that a read strobe always has the path released and a write strobe always has it driven, that status and high address hold still through a cycle, and that done follows a busy cycle. Only the bench scenarios can show that each kind gets the right status code and T-state count, that wait states appear exactly as many times as ready is held low, that the byte captured at the end of T3 is the one returned, and that idle cycles and requests made while busy are ignored.

// File: rtl/muxbus_pkg.sv
// Shared types for the multiplexed bus sequencer: cycle kinds, the
// per-kind pin attributes and the sequencer state encoding.
package muxbus_pkg;

    typedef enum logic [2:0] {
        KIND_IDLE  = 3'd0,
        KIND_FETCH = 3'd1,
        KIND_MRD   = 3'd2,
        KIND_MWR   = 3'd3,
        KIND_IORD  = 3'd4,
        KIND_IOWR  = 3'd5,
        KIND_INTA  = 3'd6,
        KIND_RSVD  = 3'd7
    } bus_kind_e;

    typedef struct packed {
        logic       strobed;   // cycle uses rd_n or wr_n and honours ready
        logic       is_read;   // rd_n strobe, path released after T1
        logic       is_write;  // wr_n strobe, path driven with data
        logic       io;        // io_m level
        logic [1:0] status;    // {s1,s0}
    } kind_attr_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACT  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/muxbus_kind_decode.sv
// Maps a latched cycle kind to its pin attributes and T-state length.
// Assumes the kind is stable for the whole cycle; reserved codes act
// as a bus idle cycle.
module muxbus_kind_decode
    import muxbus_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int FETCH_T      = 4,
    parameter int FETCH_LONG_T = 6,
    parameter int XFER_T       = 3,
    parameter int ACK_T        = 6,
    parameter int ACK_LONG_T   = 12,
    parameter int IDLE_T       = 2,
    parameter int IDLE_LONG_T  = 3
) (
    input  bus_kind_e          kind,
    input  logic               long_sel,
    output kind_attr_t         attr,
    output logic [CNT_W-1:0]   len
);

    // Attribute and length lookup per cycle kind.
    always_comb begin
        attr = '0;
        len  = CNT_W'(IDLE_T);
        case (kind)
            KIND_FETCH: begin
                attr = '{strobed: 1'b1, is_read: 1'b1, is_write: 1'b0, io: 1'b0, status: 2'b11};
                len  = long_sel ? CNT_W'(FETCH_LONG_T) : CNT_W'(FETCH_T);
            end
            KIND_MRD: begin
                attr = '{strobed: 1'b1, is_read: 1'b1, is_write: 1'b0, io: 1'b0, status: 2'b10};
                len  = CNT_W'(XFER_T);
            end
            KIND_MWR: begin
                attr = '{strobed: 1'b1, is_read: 1'b0, is_write: 1'b1, io: 1'b0, status: 2'b01};
                len  = CNT_W'(XFER_T);
            end
            KIND_IORD: begin
                attr = '{strobed: 1'b1, is_read: 1'b1, is_write: 1'b0, io: 1'b1, status: 2'b10};
                len  = CNT_W'(XFER_T);
            end
            KIND_IOWR: begin
                attr = '{strobed: 1'b1, is_read: 1'b0, is_write: 1'b1, io: 1'b1, status: 2'b01};
                len  = CNT_W'(XFER_T);
            end
            KIND_INTA: begin
                attr = '{strobed: 1'b1, is_read: 1'b1, is_write: 1'b0, io: 1'b1, status: 2'b11};
                len  = long_sel ? CNT_W'(ACK_LONG_T) : CNT_W'(ACK_T);
            end
            default: begin
                attr = '0;
                len  = long_sel ? CNT_W'(IDLE_LONG_T) : CNT_W'(IDLE_T);
            end
        endcase
    end

endmodule

// File: rtl/muxbus_tstate_fsm.sv
// T-state sequencer. Counts T-states from 1 to the cycle length,
// parks in a wait state when ready is low at the end of T2 or of a
// wait state of a strobed cycle, and pulses done after the last
// T-state. Assumes len >= 3 for strobed kinds and len >= 2 otherwise.
module muxbus_tstate_fsm
    import muxbus_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             strobed,
    input  logic             ready,
    output logic             busy,
    output logic             first_t,
    output logic             strobe_ph,
    output logic             cap_t,
    output logic             done
);

    localparam logic [CNT_W-1:0] T_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] T_TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] T_THREE = CNT_W'(3);

    seq_state_e       state_q;
    logic [CNT_W-1:0] tnum_q;

    // State, T-state counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            tnum_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_ACT;
                        tnum_q  <= T_ONE;
                    end
                end
                SEQ_ACT: begin
                    if (tnum_q == T_TWO && strobed && !ready) begin
                        state_q <= SEQ_WAIT;
                    end else if (tnum_q == len) begin
                        state_q <= SEQ_IDLE;
                        tnum_q  <= '0;
                        done    <= 1'b1;
                    end else begin
                        tnum_q <= tnum_q + T_ONE;
                    end
                end
                SEQ_WAIT: begin
                    if (ready) begin
                        state_q <= SEQ_ACT;
                        tnum_q  <= T_THREE;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    tnum_q  <= '0;
                end
            endcase
        end
    end

    // Phase flags consumed by the pin driver and the read capture.
    always_comb begin
        busy      = (state_q != SEQ_IDLE);
        first_t   = (state_q == SEQ_ACT) && (tnum_q == T_ONE);
        strobe_ph = (state_q == SEQ_WAIT) ||
                    ((state_q == SEQ_ACT) && (tnum_q == T_TWO || tnum_q == T_THREE));
        cap_t     = (state_q == SEQ_ACT) && (tnum_q == T_THREE);
    end

endmodule

// File: rtl/muxbus_pin_drive.sv
// Decodes the bus pins from the current phase and the latched request.
// Pins are decoded from registered state only, so no input reaches a
// pin in the same cycle.
module muxbus_pin_drive
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic               busy,
    input  logic               first_t,
    input  logic               strobe_ph,
    input  kind_attr_t         attr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]  ad_out,
    output logic               ad_oe,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n,
    output logic               io_m,
    output logic               s1,
    output logic               s0
);

    logic addr_ph;
    logic wdata_ph;

    // Which of the two values owns the shared path this cycle.
    always_comb begin
        addr_ph  = first_t && attr.strobed;
        wdata_ph = strobe_ph && attr.is_write;
    end

    // Strobes, status and shared-path drive.
    always_comb begin
        addr_hi = addr[ADDR_W-1:DATA_W];
        ale     = addr_ph;
        ad_oe   = addr_ph || wdata_ph;
        ad_out  = addr_ph ? addr[DATA_W-1:0] : wdata;
        rd_n    = !(strobe_ph && attr.is_read);
        wr_n    = !wdata_ph;
        io_m    = busy && attr.io;
        s1      = busy && attr.status[1];
        s0      = busy && attr.status[0];
    end

endmodule

// File: rtl/muxbus_read_capture.sv
// Holds the byte read from the shared path. Samples on the clock edge
// that ends T3 of a read cycle and keeps it until the next read.
module muxbus_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);

    // Capture register for read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cap_en) begin
            rdata <= ad_in;
        end
    end

endmodule

// File: rtl/muxbus_cycle_seq.sv
// Top of the multiplexed address/data bus sequencer. Latches one
// request while idle, decodes its kind, runs the T-state sequencer and
// drives the bus pins. Assumes the core waits for busy low before
// issuing, and that the pad ring builds the tristate from ad_out/ad_oe.
module muxbus_cycle_seq
    import muxbus_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int CNT_W        = 4,
    parameter int FETCH_T      = 4,
    parameter int FETCH_LONG_T = 6,
    parameter int XFER_T       = 3,
    parameter int ACK_T        = 6,
    parameter int ACK_LONG_T   = 12,
    parameter int IDLE_T       = 2,
    parameter int IDLE_LONG_T  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic                     req_long,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     ready,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0
);

    logic [2:0]        kind_q;
    logic              long_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              start;
    kind_attr_t        attr;
    logic [CNT_W-1:0]  len;
    logic              first_t;
    logic              strobe_ph;
    logic              cap_t;

    assign start = req_valid && !busy;

    // Request register, loaded only when a new cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= 3'd0;
            long_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind_q  <= req_kind;
            long_q  <= req_long;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    muxbus_kind_decode #(
        .CNT_W(CNT_W), .FETCH_T(FETCH_T), .FETCH_LONG_T(FETCH_LONG_T),
        .XFER_T(XFER_T), .ACK_T(ACK_T), .ACK_LONG_T(ACK_LONG_T),
        .IDLE_T(IDLE_T), .IDLE_LONG_T(IDLE_LONG_T)
    ) i_decode (
        .kind     (bus_kind_e'(kind_q)),
        .long_sel (long_q),
        .attr     (attr),
        .len      (len)
    );

    muxbus_tstate_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len       (len),
        .strobed   (attr.strobed),
        .ready     (ready),
        .busy      (busy),
        .first_t   (first_t),
        .strobe_ph (strobe_ph),
        .cap_t     (cap_t),
        .done      (done)
    );

    muxbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
        .busy      (busy),
        .first_t   (first_t),
        .strobe_ph (strobe_ph),
        .attr      (attr),
        .addr      (addr_q),
        .wdata     (wdata_q),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .io_m      (io_m),
        .s1        (s1),
        .s0        (s0)
    );

    muxbus_read_capture #(.DATA_W(DATA_W)) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_t && attr.is_read),
        .ad_in  (ad_in),
        .rdata  (rdata)
    );

endmodule

// File: rtl/muxbus_cycle_seq_chk.sv
// Protocol checker for the bus sequencer, bound to its top module.
module muxbus_cycle_seq_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic [HI_W-1:0] addr_hi,
    input logic            ad_oe,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            io_m,
    input logic            s1,
    input logic            s0
);

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_ale_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe));

    assert_ale_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_read_releases_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_write_drives_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    assert_status_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({io_m, s1, s0}));

    assert_addr_hi_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_hi));

    assert_done_after_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ale && rd_n && wr_n && !ad_oe && !io_m && !s1 && !s0));

endmodule

bind muxbus_cycle_seq muxbus_cycle_seq_chk #(.HI_W(ADDR_W - DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .addr_hi (addr_hi),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .io_m    (io_m),
    .s1      (s1),
    .s0      (s0)
);

// File: tb/test_muxbus_cycle_seq.sv
`timescale 1ns/1ps
module test_muxbus_cycle_seq;

    typedef struct {
        logic [7:0] rdata;
        int         cycles;
        string      tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic        req_long = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        ready = 1'b1;
    logic [7:0]  ad_in = 8'h0;
    logic        busy, done, ad_oe, ale, rd_n, wr_n, io_m, s1, s0;
    logic [7:0]  rdata, addr_hi, ad_out;

    int checks = 0;
    int failures = 0;
    int run_len = 0;
    bit finished = 1'b0;
    logic [7:0] held_rdata = 8'h00;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    muxbus_cycle_seq i_muxbus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .ad_in(ad_in), .busy(busy), .done(done), .rdata(rdata),
        .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0)
    );

    // Cycle lengths from R5.
    function automatic int exp_len(input logic [2:0] k, input logic lng);
        case (k)
            3'd1:    return lng ? 6 : 4;
            3'd2, 3'd3, 3'd4, 3'd5: return 3;
            3'd6:    return lng ? 12 : 6;
            default: return lng ? 3 : 2;
        endcase
    endfunction

    // {io_m,s1,s0} from R1.
    function automatic logic [2:0] exp_status(input logic [2:0] k);
        case (k)
            3'd1:    return 3'b011;
            3'd2:    return 3'b010;
            3'd3:    return 3'b001;
            3'd4:    return 3'b110;
            3'd5:    return 3'b101;
            3'd6:    return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check_vec(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issues one cycle, checks pins per T-state, queues the result.
    task automatic run_cycle(input logic [2:0] k, input logic lng, input logic [15:0] a,
                             input logic [7:0] wd, input int waits, input logic [7:0] rv,
                             input bit poke, input string tag);
        bit strobed = (k >= 3'd1) && (k <= 3'd6);
        bit is_rd   = (k == 3'd1) || (k == 3'd2) || (k == 3'd4) || (k == 3'd6);
        bit is_wr   = (k == 3'd3) || (k == 3'd5);
        int len     = exp_len(k, lng);
        int extra   = strobed ? waits : 0;
        int total   = len + extra;
        sb_item_t item;
        if (is_rd) held_rdata = rv;
        item.rdata  = held_rdata;
        item.cycles = total;
        item.tag    = tag;
        sb_q.push_back(item);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_long = lng; req_addr = a; req_wdata = wd;
        for (int p = 0; p < total; p++) begin
            int  tidx;
            bit  t1, strb, t3;
            logic [31:0] act, exp;
            @(negedge clk);
            req_valid = 1'b0;
            tidx = (p <= 1) ? p + 1 : ((strobed && p <= 1 + waits) ? 0 : p - extra + 1);
            t1   = (tidx == 1);
            t3   = (tidx == 3);
            strb = strobed && (tidx == 2 || tidx == 0 || tidx == 3);
            exp[31]    = 1'b1;
            exp[30]    = t1 && strobed;
            exp[29]    = !(strb && is_rd);
            exp[28]    = !(strb && is_wr);
            exp[27]    = (t1 && strobed) || (strb && is_wr);
            exp[26:24] = exp_status(k);
            exp[23:16] = a[15:8];
            exp[15:8]  = (t1 && strobed) ? a[7:0] : ((strb && is_wr) ? wd : 8'h00);
            exp[7:0]   = 8'h00;
            act = {busy, ale, rd_n, wr_n, ad_oe, io_m, s1, s0, addr_hi,
                   (ad_oe ? ad_out : 8'h00), 8'h00};
            check_vec($sformatf("%s T%0d R1 R2 R3 R4 R5 R6 R7 R10", tag, tidx), act, exp);
            if (strobed)
                ready = (p >= 1 && p <= 1 + waits) ? (p == 1 + waits) : 1'b1;
            else
                ready = (waits == 0);
            ad_in = t3 ? rv : ~rv;
            if (poke && p == 1) begin
                req_valid = 1'b1; req_kind = 3'd3; req_addr = 16'hFFFF; req_wdata = 8'h00;
            end
        end
        ready = 1'b1;
    endtask

    // Monitor: measures each cycle and compares it with the scoreboard (R5, R8).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) run_len++;
            if (done) begin
                sb_item_t it;
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R8 unexpected done actual=1 expected=0");
                end else begin
                    it = sb_q.pop_front();
                    if (run_len != it.cycles || rdata !== it.rdata) begin
                        failures++;
                        $display("FAIL %s R5 R8 actual=len %0d data %h expected=len %0d data %h",
                                 it.tag, run_len, rdata, it.cycles, it.rdata);
                    end
                end
                run_len = 0;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check_vec("R9 reset", {23'd0, busy, done, ale, ad_oe, rd_n, wr_n, rdata == 8'h00, 2'b00},
                  {23'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00});
        run_cycle(3'd1, 1'b0, 16'h12A5, 8'h00, 0, 8'h3C, 1'b0, "fetch");
        run_cycle(3'd1, 1'b1, 16'h8001, 8'h00, 1, 8'h81, 1'b0, "fetch_long");
        run_cycle(3'd2, 1'b0, 16'h4C33, 8'h00, 0, 8'h55, 1'b0, "mem_read");
        run_cycle(3'd2, 1'b0, 16'hFE10, 8'h00, 2, 8'hA7, 1'b0, "mem_read_wait R6");
        run_cycle(3'd3, 1'b0, 16'h0F0F, 8'hC3, 1, 8'h11, 1'b0, "mem_write R4");
        run_cycle(3'd4, 1'b0, 16'h0042, 8'h00, 0, 8'h19, 1'b0, "io_read");
        run_cycle(3'd5, 1'b0, 16'h7777, 8'h7E, 0, 8'h22, 1'b1, "io_write_poke R10");
        run_cycle(3'd6, 1'b0, 16'h3800, 8'h00, 0, 8'hEF, 1'b0, "ack");
        run_cycle(3'd6, 1'b1, 16'h2400, 8'h00, 3, 8'hCF, 1'b0, "ack_long");
        run_cycle(3'd0, 1'b0, 16'hAB00, 8'h99, 4, 8'h33, 1'b0, "idle_ready_low R7");
        run_cycle(3'd0, 1'b1, 16'h00CD, 8'h99, 0, 8'h44, 1'b0, "idle_long R7");
        run_cycle(3'd7, 1'b0, 16'h5A5A, 8'h99, 2, 8'h66, 1'b0, "reserved R1");
        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R8 missing done actual=%0d expected=0", sb_q.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule